// File: doc/BRIEF.md
# Text Raster Scan Timing Generator

This block derives every scan timing signal for a text-mode raster display from a 1 MHz clock enable. A prescaler divides the enable by four. Each wrap of the prescaler marks one character cell, meaning one 8-dot slice of a glyph row, and fires a load strobe. A 12-bit scan counter advances once per cell. Its fields give the cell column, the dot row inside the glyph and the character line. The column and line fields together address the 32 x 16 byte character RAM. The dot-row field picks the glyph row that the character ROM returns.

The counter has retrace time built in. The last two cells of each dot row and the whole last character line are blanked, which leaves 30 x 15 visible cells. The block gives a horizontal restart on the last cell of every dot row and a vertical restart on the last cell of the frame. An external dual-display reset also gives a vertical restart, and it restarts the frame at once. A flag shows that the first character line has been traced.

Top module: `text_scan_timer`

## Requirements
- R1: During and after reset, `scan_addr`, `dot_row`, `cell_load`, `h_restart`, `v_restart`, `blank` and `first_line` are all 0, and the prescaler is cleared.
- R2: `cell_load` is high for exactly one clock, during the 4th, 8th, 12th and later cycles in which `tick_1m` is high. It is never high while `tick_1m` is low.
- R3: The scan counter advances by one on each `cell_load` edge. Counter bits 4:0 are the column, bits 7:5 are the dot row and bits 11:8 are the line. `scan_addr` = {line, column} (line in bits 8:5, column in bits 4:0) and `dot_row` = counter bits 7:5.
- R4: `h_restart` is high for the whole cell in which the column is 31.
- R5: `v_restart` is high during the last cell of the frame (counter 4095). The next `cell_load` wraps the counter to 0.
- R6: When `dual_rst` is high on a clock edge, that edge clears the counter and the prescaler. `v_restart` then stays high until the next `cell_load` edge. The first load after the reset needs four enables.
- R7: `blank` is high when the column is 30 or 31, or when the line is 15.
- R8: `first_line` is low during character line 0 and high during lines 1 to 15.
- R9: While `tick_1m` and `dual_rst` are low, the counter and prescaler keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1m | input | 1 | 1 MHz master clock enable, one clock wide |
| dual_rst | input | 1 | Dual-display frame restart |
| scan_addr | output | 9 | Character RAM scan address {line, column} |
| dot_row | output | 3 | Dot row within the glyph |
| cell_load | output | 1 | Cell load strobe (combinational with `tick_1m`) |
| h_restart | output | 1 | Horizontal sweep restart, last cell of each dot row |
| v_restart | output | 1 | Vertical sweep restart |
| first_line | output | 1 | First character line has been traced |
| blank | output | 1 | Retrace blanking |

## Verification
`cell_load` is combinational. It is due in the same cycle as the fourth enable, so the bench samples it 1 ns after driving `tick_1m` at the falling edge, before the rising edge. The address, dot row and every decoded flag come from registers and change on the rising edge that sees `cell_load` (or `dual_rst`). The bench therefore samples them at the following falling edge. Long advances hold `tick_1m` high for exactly four clocks per cell, starting with the prescaler at zero. This keeps the counter value the bench expects exact across row, line and frame wraps.

// File: rtl/text_scan_timer.sv
`timescale 1ns/1ps
module text_scan_timer #(
  parameter int COL_BITS    = 5,
  parameter int ROW_BITS    = 3,
  parameter int LINE_BITS   = 4,
  parameter int PRESCALE    = 4,
  parameter int BLANK_COLS  = 2,
  parameter int BLANK_LINES = 1,
  localparam int AW = COL_BITS + LINE_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_1m,
  input  logic                dual_rst,
  output logic [AW-1:0]       scan_addr,
  output logic [ROW_BITS-1:0] dot_row,
  output logic                cell_load,
  output logic                h_restart,
  output logic                v_restart,
  output logic                first_line,
  output logic                blank
);
  localparam int CW = COL_BITS + ROW_BITS + LINE_BITS;
  localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);
  localparam int NCOLS  = 1 << COL_BITS;
  localparam int NLINES = 1 << LINE_BITS;

  logic [PW-1:0] pre;
  logic [CW-1:0] cnt;
  logic          ext_vr;

  wire [COL_BITS-1:0]  col  = cnt[COL_BITS-1:0];
  wire [LINE_BITS-1:0] line = cnt[CW-1 -: LINE_BITS];

  assign cell_load = tick_1m && (pre == PRE_LAST) && !dual_rst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre    <= '0;
      cnt    <= '0;
      ext_vr <= 1'b0;
    end else if (dual_rst) begin
      pre    <= '0;
      cnt    <= '0;
      ext_vr <= 1'b1;
    end else if (tick_1m) begin
      if (pre == PRE_LAST) begin
        pre    <= '0;
        cnt    <= cnt + 1'b1;
        ext_vr <= 1'b0;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  assign scan_addr  = {line, col};
  assign dot_row    = cnt[COL_BITS +: ROW_BITS];
  assign h_restart  = &col;
  assign v_restart  = (&cnt) | ext_vr;
  assign first_line = |line;
  assign blank      = (int'(col) >= NCOLS - BLANK_COLS) ||
                      (int'(line) >= NLINES - BLANK_LINES);
endmodule

module text_scan_timer_chk #(
  parameter int AW = 9,
  parameter int RW = 3,
  parameter int COL_BITS = 5,
  parameter int BLANK_COLS = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_1m,
  input logic          dual_rst,
  input logic [AW-1:0] scan_addr,
  input logic [RW-1:0] dot_row,
  input logic          cell_load,
  input logic          h_restart,
  input logic          v_restart,
  input logic          blank
);
  wire [AW+RW-1:0] pos = {scan_addr[AW-1:COL_BITS], dot_row, scan_addr[COL_BITS-1:0]};

  // R2
  load_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_load |-> tick_1m);
  // R3
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_load |=> pos == $past(pos) + 1'b1);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_1m && !dual_rst) |=> $stable(pos));
  // R6
  dual_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dual_rst |=> (pos == '0) && v_restart && !cell_load);
  // R4
  row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_restart && cell_load) |=> scan_addr[COL_BITS-1:0] == '0);
  // R7
  hblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(scan_addr[COL_BITS-1:0]) >= (1 << COL_BITS) - BLANK_COLS) |-> blank);
endmodule

bind text_scan_timer text_scan_timer_chk #(
  .AW(AW), .RW(ROW_BITS), .COL_BITS(COL_BITS), .BLANK_COLS(BLANK_COLS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_1m(tick_1m), .dual_rst(dual_rst),
  .scan_addr(scan_addr), .dot_row(dot_row), .cell_load(cell_load),
  .h_restart(h_restart), .v_restart(v_restart), .blank(blank)
);

// File: tb/text_scan_timer_test.sv
`timescale 1ns/1ps
module text_scan_timer_test;
  logic clk = 0, rst_n = 0, tick_1m = 0, dual_rst = 0;
  logic [8:0] scan_addr;
  logic [2:0] dot_row;
  logic cell_load, h_restart, v_restart, first_line, blank;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  text_scan_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_1m(tick_1m), .dual_rst(dual_rst),
    .scan_addr(scan_addr), .dot_row(dot_row), .cell_load(cell_load),
    .h_restart(h_restart), .v_restart(v_restart), .first_line(first_line),
    .blank(blank)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // hold tick_1m high for 4*n clocks; prescaler must be 0 on entry
  task automatic run_cells(int n);
    @(negedge clk) tick_1m = 1;
    repeat (4*n) @(negedge clk);
    tick_1m = 0;
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 addr", scan_addr, 0);
    check("R1 row", dot_row, 0);
    check("R1 flags", {cell_load, h_restart, v_restart, first_line, blank}, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", {scan_addr, dot_row}, 0);
  endtask

  task automatic t_prescale();
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk) tick_1m = 1;
      #1 check($sformatf("R2 load on enable %0d", i), cell_load, (i % 4 == 0));
      @(negedge clk) tick_1m = 0;
      #1 check("R2 load without enable", cell_load, 0);
    end
    check("R3 two cells counted", scan_addr, 2);
  endtask

  task automatic t_hold();
    repeat (10) @(negedge clk);
    check("R9 idle holds addr", scan_addr, 2);
    run_cells(0);
    @(negedge clk) tick_1m = 1;
    @(negedge clk) tick_1m = 0;
    repeat (5) @(negedge clk);
    tick_1m = 1;
    @(negedge clk) tick_1m = 1;
    #1 check("R9 prescaler held across gap", cell_load, 0);
    @(negedge clk) tick_1m = 1;
    #1 check("R9 fourth enable loads", cell_load, 1);
    @(negedge clk) tick_1m = 0;
    check("R3 addr 3", scan_addr, 3);
  endtask

  task automatic t_fields();
    run_cells(26);
    check("R7 col 29 visible", blank, 0);
    check("R4 col 29 no hr", h_restart, 0);
    run_cells(1);
    check("R7 col 30 blank", blank, 1);
    run_cells(1);
    check("R4 col 31 hr", h_restart, 1);
    run_cells(1);
    check("R3 row 1 addr", scan_addr, 0);
    check("R3 row 1 dot_row", dot_row, 1);
    check("R4 hr drops", h_restart, 0);
    check("R8 line 0", first_line, 0);
    run_cells(224);
    check("R3 line 1 addr", scan_addr, 9'h020);
    check("R3 line 1 dot_row", dot_row, 0);
    check("R8 line 1", first_line, 1);
    check("R7 line 1 visible", blank, 0);
  endtask

  task automatic t_frame();
    run_cells(3840 - 256);
    check("R7 line 15 blank", blank, 1);
    check("R3 line 15 addr", scan_addr, 9'h1E0);
    check("R5 no vr early", v_restart, 0);
    run_cells(255);
    check("R5 vr at end", v_restart, 1);
    check("R4 hr at end", h_restart, 1);
    run_cells(1);
    check("R5 wrap addr", {scan_addr, dot_row}, 0);
    check("R5 vr drops", v_restart, 0);
    check("R8 wrap clears", first_line, 0);
  endtask

  task automatic t_dual();
    run_cells(300);
    @(negedge clk) tick_1m = 1;
    @(negedge clk);
    @(negedge clk) tick_1m = 0;
    dual_rst = 1;
    @(negedge clk) dual_rst = 0;
    check("R6 addr cleared", {scan_addr, dot_row}, 0);
    check("R6 vr raised", v_restart, 1);
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk) tick_1m = 1;
      #1 check("R6 prescaler cleared", cell_load, 0);
    end
    @(negedge clk) tick_1m = 1;
    #1 check("R6 fourth enable loads", cell_load, 1);
    check("R6 vr held", v_restart, 1);
    @(negedge clk) tick_1m = 0;
    check("R6 vr released", v_restart, 0);
    check("R6 addr 1", scan_addr, 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_prescale();
        t_hold();
        t_fields();
        t_frame();
        t_dual();
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule